// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the processor-facing port of a display controller. An 8-bit host reaches it over a short parallel bus. A static select pin sets the bus style. In the first style, two active-low pins act as separate read and write strobes. In the second style, one pin is a high-active enable clock and the other is a read/not-write level. In both styles an active-low chip select qualifies every cycle. An address line marks each byte as either a command or a parameter/data byte.

All host pins pass through a multi-stage synchroniser into the controller clock. A write is taken when the synchronised write strobe (or the enable, in the second style) ends. The byte goes into a single-entry holding register, and the controller drains that register with a take pulse. A read drives an output-enable for the tri-state driver at the chip edge. A read with the address line high returns a status byte with a busy flag. A read with the address line low returns a byte supplied by the controller, and the port signals to the controller when that read has ended.

The block leaves reset only after its reset input has stayed low long enough. A shorter low pulse is ignored.

Top module: `hbus_port`

## Requirements
- R1: Internal state clears only after `rst_n` has been sampled low on RST_MIN consecutive clock edges (default 16). A shorter low pulse leaves a pending byte intact. After a qualifying reset, `byte_valid`, `dout_oe` and `rd_taken` are 0.
- R2: With `mode_sel`=0, a write is a cycle with `cs_n` low and `wr_rw` low. The byte is captured when `wr_rw` returns high. `byte_data` carries `din`, and `byte_cmd` carries `a0` (1 = command, 0 = parameter/data).
- R3: With `mode_sel`=1, a write is a cycle with `cs_n` low, `rd_e` high and `wr_rw` low. The byte is captured when `rd_e` falls, with `byte_cmd` equal to `a0`.
- R4: While `cs_n` is high, strobe activity captures nothing and never asserts `dout_oe`.
- R5: `dout_oe` is high only during a selected read. It rises within 3 clock edges of the read strobe starting and falls within 3 edges of it ending.
- R6: A read with `a0`=1 drives a status byte: bit 7 is 1 while a captured byte is pending, and bits 6..0 are 0.
- R7: A read with `a0`=0 drives `rd_data`. When that read ends, `rd_taken` pulses for exactly one cycle. A status read produces no pulse.
- R8: `byte_valid` stays high with stable `byte_data`/`byte_cmd` until `byte_take`. A write that completes while a byte is pending and not being taken is discarded.
- R9: With `mode_sel`=1, no transaction happens while `rd_e` is low, whatever the level of `wr_rw`. With `mode_sel`=0, `rd_e` low with `wr_rw` high is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, qualified by minimum low time |
| mode_sel | input | 1 | Bus style: 0 separate strobes, 1 enable plus R/W |
| cs_n | input | 1 | Active-low chip select |
| a0 | input | 1 | 1 = command/status, 0 = parameter/data |
| rd_e | input | 1 | Read strobe (low active) or enable clock (high active) |
| wr_rw | input | 1 | Write strobe (low active) or read/not-write level |
| din | input | 8 | Host data into the port |
| dout | output | 8 | Host data out of the port |
| dout_oe | output | 1 | Drive enable for the external tri-state data buffer |
| rd_data | input | 8 | Byte the controller offers for data reads |
| rd_taken | output | 1 | One-cycle pulse after a data read ends |
| byte_valid | output | 1 | Holding register full |
| byte_cmd | output | 1 | Held byte is a command |
| byte_data | output | 8 | Held byte |
| byte_take | input | 1 | Controller consumes the held byte |

## Verification
The main path is driven with writes and reads in both bus styles and with both address values. This shows that the mode pin really remaps the two strobe pins and that the address line reaches both the command flag and the read multiplexer. Status reads taken with a byte pending and with none pending separate the busy flag from the constant status bits. Cycles with the chip select high, and enable-style cycles with the enable held low, separate real strobe decoding from simple pin watching. A back-to-back write without a take, and a reset pulse shorter than the minimum, exercise the drop rule and the reset qualifier.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int HB_DW      = 8;
    localparam int HB_SYNC    = 2;
    localparam int HB_RST_MIN = 16;

    typedef enum logic {
        BUS_SPLIT  = 1'b0,   // separate read and write strobes
        BUS_ENABLE = 1'b1    // enable clock plus read/not-write level
    } bus_style_e;

endpackage

// File: rtl/hbus_rst_filt.sv
module hbus_rst_filt #(
    parameter int RST_MIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic core_rst,
    output logic armed
);
    localparam int CW = $clog2(RST_MIN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(RST_MIN);

    typedef struct packed {
        logic [CW-1:0] low_cnt;
        logic          armed;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (rst_n) begin
            rf_d.low_cnt = '0;
        end else if (rf_q.low_cnt != CNT_TOP) begin
            rf_d.low_cnt = rf_q.low_cnt + 1'b1;
        end
        if (rf_q.low_cnt == CNT_TOP) begin
            rf_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        rf_q <= rf_d;
    end

    assign core_rst = (rf_q.low_cnt == CNT_TOP);
    assign armed    = rf_q.armed;

endmodule

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) stg_q[s] <= async_i;
            end else begin : g_next
                always_ff @(posedge clk) stg_q[s] <= stg_q[s-1];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
(
    input  bus_style_e style,
    input  logic       cs_n,
    input  logic       rd_e,
    input  logic       wr_rw,
    output logic       rd_act,
    output logic       wr_act
);
    logic sel;

    always_comb begin
        sel = !cs_n;
        if (style == BUS_ENABLE) begin
            // cycle bounded by select AND enable
            rd_act = sel && rd_e && wr_rw;
            wr_act = sel && rd_e && !wr_rw;
        end else begin
            rd_act = sel && !rd_e;
            wr_act = sel && !wr_rw && rd_e;
        end
    end

endmodule

// File: rtl/hbus_port.sv
module hbus_port
    import hbus_pkg::*;
#(
    parameter int DW      = HB_DW,
    parameter int SYNC    = HB_SYNC,
    parameter int RST_MIN = HB_RST_MIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          cs_n,
    input  logic          a0,
    input  logic          rd_e,
    input  logic          wr_rw,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    input  logic [DW-1:0] rd_data,
    output logic          rd_taken,
    output logic          byte_valid,
    output logic          byte_cmd,
    output logic [DW-1:0] byte_data,
    input  logic          byte_take
);
    localparam int SW = DW + 4;

    typedef struct packed {
        logic          wr_prev;
        logic          rd_prev;
        logic [DW-1:0] shadow;
        logic          shadow_cmd;
        logic          rd_cmd;
        logic          hold_v;
        logic          hold_cmd;
        logic [DW-1:0] hold_d;
        logic          oe;
        logic [DW-1:0] dout;
        logic          taken;
    } port_st_t;

    logic          core_rst, armed;
    logic [SW-1:0] pins_s;
    logic          cs_n_s, a0_s, rd_e_s, wr_rw_s;
    logic [DW-1:0] din_s;
    logic          rd_act, wr_act;
    logic [DW-1:0] status_b;
    port_st_t      st_d, st_q;

    hbus_rst_filt #(.RST_MIN(RST_MIN)) u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_rst (core_rst),
        .armed    (armed)
    );

    hbus_sync #(.W(SW), .STAGES(SYNC)) u_sync (
        .clk     (clk),
        .async_i ({cs_n, a0, rd_e, wr_rw, din}),
        .sync_o  (pins_s)
    );

    assign {cs_n_s, a0_s, rd_e_s, wr_rw_s, din_s} = pins_s;

    hbus_decode u_dec (
        .style  (bus_style_e'(mode_sel)),
        .cs_n   (cs_n_s),
        .rd_e   (rd_e_s),
        .wr_rw  (wr_rw_s),
        .rd_act (rd_act),
        .wr_act (wr_act)
    );

    assign status_b = {st_q.hold_v, {(DW-1){1'b0}}};

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;

        if (byte_take && st_q.hold_v) begin
            st_d.hold_v = 1'b0;
        end

        // write path: track data while active, commit on strobe end
        if (wr_act) begin
            st_d.shadow     = din_s;
            st_d.shadow_cmd = a0_s;
        end
        if (!wr_act && st_q.wr_prev && (!st_q.hold_v || byte_take)) begin
            st_d.hold_v   = 1'b1;
            st_d.hold_d   = st_q.shadow;
            st_d.hold_cmd = st_q.shadow_cmd;
        end
        st_d.wr_prev = wr_act;

        // read path
        st_d.oe = rd_act;
        if (rd_act) begin
            st_d.rd_cmd = a0_s;
            st_d.dout   = a0_s ? status_b : rd_data;
        end
        if (!rd_act && st_q.rd_prev && !st_q.rd_cmd) begin
            st_d.taken = 1'b1;
        end
        st_d.rd_prev = rd_act;
    end

    always_ff @(posedge clk) begin
        if (core_rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout       = st_q.dout;
    assign dout_oe    = st_q.oe;
    assign rd_taken   = st_q.taken;
    assign byte_valid = st_q.hold_v;
    assign byte_cmd   = st_q.hold_cmd;
    assign byte_data  = st_q.hold_d;

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!armed)
        core_rst |=> (!byte_valid && !dout_oe && !rd_taken)); // R1

    AST_CAPTURE_DONE: assert property (@(posedge clk) disable iff (core_rst || !armed)
        (st_q.wr_prev && !wr_act && !byte_valid) |=> byte_valid); // R2

    AST_OE_NOT_WRITE: assert property (@(posedge clk) disable iff (core_rst || !armed)
        dout_oe |-> !$past(wr_act)); // R5

    AST_TAKEN_SINGLE: assert property (@(posedge clk) disable iff (core_rst || !armed)
        rd_taken |=> !rd_taken); // R7

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (core_rst || !armed)
        (byte_valid && !byte_take) |=>
            (byte_valid && $stable(byte_data) && $stable(byte_cmd))); // R8

endmodule

// File: tb/test_hbus_port.sv
`timescale 1ns/1ps
module test_hbus_port;
    localparam int RST_MIN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       mode_sel = 1'b0;
    logic       cs_n = 1'b1;
    logic       a0 = 1'b0;
    logic       rd_e = 1'b1;
    logic       wr_rw = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] rd_data = 8'h00;
    logic       rd_taken;
    logic       byte_valid;
    logic       byte_cmd;
    logic [7:0] byte_data;
    logic       byte_take = 1'b0;

    int checks = 0;
    int errors = 0;
    int taken_cnt = 0;

    always #2 clk = ~clk;

    hbus_port #(.RST_MIN(RST_MIN)) i_hbus_port (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .a0(a0),
        .rd_e(rd_e), .wr_rw(wr_rw), .din(din), .dout(dout), .dout_oe(dout_oe),
        .rd_data(rd_data), .rd_taken(rd_taken), .byte_valid(byte_valid),
        .byte_cmd(byte_cmd), .byte_data(byte_data), .byte_take(byte_take)
    );

    always @(posedge clk) if (rd_taken) taken_cnt++;

    typedef struct packed {
        logic       m;
        logic       a;
        logic       rd;
        logic [7:0] wd;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b1, 1'b0, 8'h3C, 8'h3C},
        '{1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
        '{1'b1, 1'b1, 1'b0, 8'h5A, 8'h5A},
        '{1'b1, 1'b0, 1'b0, 8'hC3, 8'hC3},
        '{1'b0, 1'b0, 1'b1, 8'h96, 8'h96},
        '{1'b1, 1'b0, 1'b1, 8'h69, 8'h69},
        '{1'b0, 1'b1, 1'b1, 8'hFF, 8'h00},
        '{1'b1, 1'b1, 1'b1, 8'hFF, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go_idle(input logic m);
        @(negedge clk);
        cs_n = 1'b1; mode_sel = m;
        rd_e = m ? 1'b0 : 1'b1;
        wr_rw = 1'b1;
    endtask

    task automatic strobe_on(input logic m, input logic av, input logic rd,
                             input logic [7:0] d, input logic sel);
        @(negedge clk);
        a0 = av; din = d; rd_data = d; cs_n = !sel;
        if (m) begin
            wr_rw = rd; rd_e = 1'b1;
        end else if (rd) begin
            rd_e = 1'b0;
        end else begin
            wr_rw = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe_off(input logic m);
        if (m) rd_e = 1'b0;
        else begin rd_e = 1'b1; wr_rw = 1'b1; end
        @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        if (m) wr_rw = 1'b1;
    endtask

    task automatic take_byte;
        byte_take = 1'b1;
        @(negedge clk);
        byte_take = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic m, input logic av, input logic [7:0] d);
        go_idle(m);
        strobe_on(m, av, 1'b0, d, 1'b1);
        strobe_off(m);
    endtask

    task automatic full_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (RST_MIN + 2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int tc0;
        repeat (3) @(negedge clk);
        full_reset();
        chk("R1 reset valid", {7'b0, byte_valid}, 8'h00);
        chk("R1 reset oe", {7'b0, dout_oe}, 8'h00);

        for (int i = 0; i < 8; i++) begin
            vec_t v = VECS[i];
            go_idle(v.m);
            tc0 = taken_cnt;
            strobe_on(v.m, v.a, v.rd, v.wd, 1'b1);
            if (v.rd) begin
                chk("R5 oe during read", {7'b0, dout_oe}, 8'h01);
                chk(v.a ? "R6 status idle" : "R7 data read", dout, v.exp);
            end
            strobe_off(v.m);
            if (v.rd) begin
                chk("R5 oe released", {7'b0, dout_oe}, 8'h00);
                chk("R7 taken pulses", 8'(taken_cnt - tc0), v.a ? 8'd0 : 8'd1);
            end else begin
                chk(v.m ? "R3 valid" : "R2 valid", {7'b0, byte_valid}, 8'h01);
                chk(v.m ? "R3 data" : "R2 data", byte_data, v.exp);
                chk(v.m ? "R3 cmd flag" : "R2 cmd flag", {7'b0, byte_cmd}, {7'b0, v.a});
                take_byte();
                chk("R8 take clears", {7'b0, byte_valid}, 8'h00);
            end
        end

        // R4: deselected write and read
        go_idle(1'b0);
        strobe_on(1'b0, 1'b0, 1'b0, 8'h11, 1'b0);
        strobe_off(1'b0);
        chk("R4 no capture deselected", {7'b0, byte_valid}, 8'h00);
        go_idle(1'b0);
        strobe_on(1'b0, 1'b0, 1'b1, 8'h22, 1'b0);
        chk("R4 no oe deselected", {7'b0, dout_oe}, 8'h00);
        strobe_off(1'b0);

        // R9: enable style with enable low and R/W low
        go_idle(1'b1);
        @(negedge clk);
        cs_n = 1'b0; wr_rw = 1'b0; din = 8'h33;
        repeat (6) @(negedge clk);
        chk("R9 no oe enable low", {7'b0, dout_oe}, 8'h00);
        cs_n = 1'b1; wr_rw = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 no capture enable low", {7'b0, byte_valid}, 8'h00);

        // R6 busy and R8 drop on overrun
        do_write(1'b0, 1'b0, 8'h4D);
        do_write(1'b1, 1'b1, 8'hE2);
        chk("R8 first kept", byte_data, 8'h4D);
        chk("R8 cmd kept", {7'b0, byte_cmd}, 8'h00);
        go_idle(1'b0);
        strobe_on(1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
        chk("R6 busy status", dout, 8'h80);
        strobe_off(1'b0);

        // R1 short pulse keeps state, full reset clears
        @(negedge clk);
        rst_n = 1'b0;
        repeat (RST_MIN - 4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 short pulse ignored", {7'b0, byte_valid}, 8'h01);
        chk("R1 data after short pulse", byte_data, 8'h4D);
        full_reset();
        chk("R1 full reset clears", {7'b0, byte_valid}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule